// File: doc/BRIEF.md
# Banked UART Configuration Register File

This block is the byte-wide control and configuration storage of a 16550-class UART. A host reaches it through a 5-bit register offset, a write strobe and a read strobe. Its outputs feed the rest of the UART: the line format, modem control, interrupt mask, divisor, FIFO settings, flow-control characters and trigger levels. The serial shifter, the FIFOs and the baud generator sit elsewhere. Their status bytes come in on input ports and are multiplexed onto the read path.

Only eight low offsets exist, but more registers than that must be reached through them. The block therefore switches banks using values held in its own registers. With line-control bit 7 set, offsets 0 and 1 reach the divisor latch bytes. With the whole line-control byte equal to 0xBF, a key bank opens the enhanced-feature register and the four flow-control characters. With enhanced-feature bit 4 and modem-control bit 6 both set, offsets 6 and 7 reach the transmission-control and trigger-level registers.

Writes take effect at the clock edge. Reads are combinational while the read strobe is high. Offset 0 in the normal bank is the data port. Writing it pulses a transmit push, and reading it pulses a receive pop.

Top module: `uart_cfg_regfile`

## Requirements
- R1: After synchronous reset, every stored register reads 0x00 and drives 0x00, except the mode register at offset 8, which holds 0x07.
- R2: In the normal bank (line control not 0xBF, bit 7 clear), the following offsets are read/write storage: 1 interrupt enable, 3 line control, 4 modem control, 7 scratch, 8 mode, 0x10 supplementary control. Reads of offset 2, 5, 6 and 0x11 return the interrupt-identification, line-status, modem-status and supplementary-status inputs.
- R3: While line-control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes. These accesses neither push nor pop data.
- R4: While line control equals 0xBF, offset 2 reaches the enhanced-feature register. Offsets 4, 5, 6 and 7 reach the first on-character, the second on-character, the first off-character and the second off-character.
- R5: While enhanced-feature bit 4 and modem-control bit 6 are both 1, and the key bank is not open, offset 6 reaches the transmission-control register and offset 7 reaches the trigger-level register.
- R6: A normal-bank write to offset 2 loads FIFO control only when enhanced-feature bit 4 is 1. Otherwise the FIFO control output keeps its value.
- R7: FIFO control bit 1 (receive clear) and bit 2 (transmit clear) each give a single-cycle pulse on their clear output in the cycle after the write. The FIFO control output shows bits 2:1 as 0. Bit 0 (enable), bit 3 (DMA), bits 5:4 (transmit trigger) and bits 7:6 (receive trigger) are held as written.
- R8: Modem-control bit 6 changes on a write only while enhanced-feature bit 4 is 1. The other modem-control bits are always written.
- R9: A read of an unmapped offset (for example 0x1F) returns 0x00 and raises no pop. A write to it changes no register.
- R10: In the normal bank, a write to offset 0 raises the transmit push in that cycle. A read of offset 0 returns the receive-data input and raises the receive pop in that cycle.
- R11: When read and write strobes are high in the same cycle, the bank is chosen from the pre-write register state and the read returns the pre-write value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, 0 when rd_en is low |
| rx_data_in | input | 8 | Receive FIFO head byte |
| iir_in | input | 8 | Interrupt identification byte |
| lsr_in | input | 8 | Line status byte |
| msr_in | input | 8 | Modem status byte |
| ssr_in | input | 8 | Supplementary status byte |
| tx_push | output | 1 | Transmit byte push (data is wr_data) |
| rx_pop | output | 1 | Receive byte pop |
| rx_clr | output | 1 | Receive FIFO clear pulse |
| tx_clr | output | 1 | Transmit FIFO clear pulse |
| ier_o | output | 8 | Interrupt enable |
| lcr_o | output | 8 | Line control |
| mcr_o | output | 8 | Modem control |
| fcr_o | output | 8 | FIFO control, clear bits read 0 |
| efr_o | output | 8 | Enhanced features |
| div_lo_o | output | 8 | Divisor low byte |
| div_hi_o | output | 8 | Divisor high byte |
| xon1_o | output | 8 | First on-character |
| xon2_o | output | 8 | Second on-character |
| xoff1_o | output | 8 | First off-character |
| xoff2_o | output | 8 | Second off-character |
| tcr_o | output | 8 | Transmission control |
| tlr_o | output | 8 | Trigger level |
| mdr_o | output | 8 | Mode |
| scr_o | output | 8 | Supplementary control |

## Verification
Two functions can coincide in one cycle. The first is a write that changes the bank-selecting line-control byte while the same offset is being read. The second is a data-port push and a data-port pop sharing one cycle. The bench raises both strobes together, once on offset 3 with a value that sets bit 7 and once on offset 0 in the normal bank. It expects the read to show the old line-control value, or the receive-data input with both push and pop high. A follow-up read then confirms that the new bank is in effect.

// File: rtl/uart_cfg_pkg.sv
`timescale 1ns/1ps
package uart_cfg_pkg;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned FLOW_N = 4;

    localparam logic [DATA_W-1:0] KEY_BANK_VAL = 8'hBF;
    localparam logic [DATA_W-1:0] MODE_RST_VAL = 8'h07;
    localparam int unsigned EFR_ENH_BIT = 4;
    localparam int unsigned MCR_ALT_BIT = 6;
    localparam int unsigned LCR_DIV_BIT = 7;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_DATA, SEL_IER, SEL_FIFO, SEL_LCR, SEL_MCR,
        SEL_LSR, SEL_MSR, SEL_SPR, SEL_MODE, SEL_SCR, SEL_SSR,
        SEL_DIVLO, SEL_DIVHI, SEL_EFR, SEL_XON1, SEL_XON2,
        SEL_XOFF1, SEL_XOFF2, SEL_TCR, SEL_TLR
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] ier;
        logic [DATA_W-1:0] lcr;
        logic [DATA_W-1:0] mcr;
        logic [DATA_W-1:0] fcr;
        logic [DATA_W-1:0] efr;
        logic [DATA_W-1:0] div_lo;
        logic [DATA_W-1:0] div_hi;
        logic [FLOW_N-1:0][DATA_W-1:0] flow;
        logic [DATA_W-1:0] tcr;
        logic [DATA_W-1:0] tlr;
        logic [DATA_W-1:0] spr;
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] scr;
    } cfg_regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] rx_data;
        logic [DATA_W-1:0] iir;
        logic [DATA_W-1:0] lsr;
        logic [DATA_W-1:0] msr;
        logic [DATA_W-1:0] ssr;
    } status_t;

    function automatic reg_sel_e decode_offset(
        input logic [ADDR_W-1:0] off,
        input logic [DATA_W-1:0] lcr,
        input logic              enh,
        input logic              mcr_alt
    );
        reg_sel_e s;
        unique case (off)
            5'h00:   s = SEL_DATA;
            5'h01:   s = SEL_IER;
            5'h02:   s = SEL_FIFO;
            5'h03:   s = SEL_LCR;
            5'h04:   s = SEL_MCR;
            5'h05:   s = SEL_LSR;
            5'h06:   s = SEL_MSR;
            5'h07:   s = SEL_SPR;
            5'h08:   s = SEL_MODE;
            5'h10:   s = SEL_SCR;
            5'h11:   s = SEL_SSR;
            default: s = SEL_NONE;
        endcase
        if (enh && mcr_alt) begin
            if (off == 5'h06) s = SEL_TCR;
            if (off == 5'h07) s = SEL_TLR;
        end
        if (lcr[LCR_DIV_BIT]) begin
            if (off == 5'h00) s = SEL_DIVLO;
            if (off == 5'h01) s = SEL_DIVHI;
        end
        if (lcr == KEY_BANK_VAL) begin
            unique case (off)
                5'h02:   s = SEL_EFR;
                5'h04:   s = SEL_XON1;
                5'h05:   s = SEL_XON2;
                5'h06:   s = SEL_XOFF1;
                5'h07:   s = SEL_XOFF2;
                default: ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/uart_cfg_decode.sv
`timescale 1ns/1ps
module uart_cfg_decode
    import uart_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] lcr,
    input  logic              enh,
    input  logic              mcr_alt,
    output reg_sel_e          sel
);
    always_comb sel = decode_offset(addr, lcr, enh, mcr_alt);
endmodule

// File: rtl/uart_cfg_rdmux.sv
`timescale 1ns/1ps
module uart_cfg_rdmux
    import uart_cfg_pkg::*;
(
    input  reg_sel_e          sel,
    input  logic              rd_en,
    input  cfg_regs_t         regs,
    input  status_t           sts,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] val;

    always_comb begin
        unique case (sel)
            SEL_DATA:  val = sts.rx_data;
            SEL_IER:   val = regs.ier;
            SEL_FIFO:  val = sts.iir;
            SEL_LCR:   val = regs.lcr;
            SEL_MCR:   val = regs.mcr;
            SEL_LSR:   val = sts.lsr;
            SEL_MSR:   val = sts.msr;
            SEL_SPR:   val = regs.spr;
            SEL_MODE:  val = regs.mode;
            SEL_SCR:   val = regs.scr;
            SEL_SSR:   val = sts.ssr;
            SEL_DIVLO: val = regs.div_lo;
            SEL_DIVHI: val = regs.div_hi;
            SEL_EFR:   val = regs.efr;
            SEL_XON1:  val = regs.flow[0];
            SEL_XON2:  val = regs.flow[1];
            SEL_XOFF1: val = regs.flow[2];
            SEL_XOFF2: val = regs.flow[3];
            SEL_TCR:   val = regs.tcr;
            SEL_TLR:   val = regs.tlr;
            default:   val = '0;
        endcase
        rd_data = rd_en ? val : '0;
    end
endmodule

// File: rtl/uart_cfg_regfile.sv
`timescale 1ns/1ps
module uart_cfg_regfile
    import uart_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic [7:0] rx_data_in,
    input  logic [7:0] iir_in,
    input  logic [7:0] lsr_in,
    input  logic [7:0] msr_in,
    input  logic [7:0] ssr_in,
    output logic       tx_push,
    output logic       rx_pop,
    output logic       rx_clr,
    output logic       tx_clr,
    output logic [7:0] ier_o,
    output logic [7:0] lcr_o,
    output logic [7:0] mcr_o,
    output logic [7:0] fcr_o,
    output logic [7:0] efr_o,
    output logic [7:0] div_lo_o,
    output logic [7:0] div_hi_o,
    output logic [7:0] xon1_o,
    output logic [7:0] xon2_o,
    output logic [7:0] xoff1_o,
    output logic [7:0] xoff2_o,
    output logic [7:0] tcr_o,
    output logic [7:0] tlr_o,
    output logic [7:0] mdr_o,
    output logic [7:0] scr_o
);

    cfg_regs_t regs_q;
    status_t   sts;
    reg_sel_e  sel;
    logic      enh;
    logic      fcr_wr;
    logic      rx_clr_q, tx_clr_q;

    assign enh = regs_q.efr[EFR_ENH_BIT];
    assign sts = '{rx_data: rx_data_in, iir: iir_in, lsr: lsr_in,
                   msr: msr_in, ssr: ssr_in};

    uart_cfg_decode u_decode (
        .addr    (addr),
        .lcr     (regs_q.lcr),
        .enh     (enh),
        .mcr_alt (regs_q.mcr[MCR_ALT_BIT]),
        .sel     (sel)
    );

    uart_cfg_rdmux u_rdmux (
        .sel     (sel),
        .rd_en   (rd_en),
        .regs    (regs_q),
        .sts     (sts),
        .rd_data (rd_data)
    );

    assign fcr_wr = wr_en && (sel == SEL_FIFO) && enh;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q      <= '0;
            regs_q.mode <= MODE_RST_VAL;
            rx_clr_q    <= 1'b0;
            tx_clr_q    <= 1'b0;
        end else begin
            rx_clr_q <= fcr_wr && wr_data[1];
            tx_clr_q <= fcr_wr && wr_data[2];
            if (fcr_wr)
                regs_q.fcr <= {wr_data[7:3], 2'b00, wr_data[0]};
            if (wr_en) begin
                unique case (sel)
                    SEL_IER:   regs_q.ier    <= wr_data;
                    SEL_LCR:   regs_q.lcr    <= wr_data;
                    SEL_MCR:   regs_q.mcr    <= {wr_data[7],
                                                 enh ? wr_data[6] : regs_q.mcr[6],
                                                 wr_data[5:0]};
                    SEL_SPR:   regs_q.spr    <= wr_data;
                    SEL_MODE:  regs_q.mode   <= wr_data;
                    SEL_SCR:   regs_q.scr    <= wr_data;
                    SEL_DIVLO: regs_q.div_lo <= wr_data;
                    SEL_DIVHI: regs_q.div_hi <= wr_data;
                    SEL_EFR:   regs_q.efr    <= wr_data;
                    SEL_TCR:   regs_q.tcr    <= wr_data;
                    SEL_TLR:   regs_q.tlr    <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // flow-control characters: one slot per key-bank offset 4..7
    for (genvar g = 0; g < FLOW_N; g++) begin : g_flow
        localparam reg_sel_e SLOT_SEL = reg_sel_e'(SEL_XON1 + g);
        always_ff @(posedge clk) begin
            if (rst)
                regs_q.flow[g] <= '0;
            else if (wr_en && sel == SLOT_SEL)
                regs_q.flow[g] <= wr_data;
        end
    end

    assign tx_push  = wr_en && (sel == SEL_DATA);
    assign rx_pop   = rd_en && (sel == SEL_DATA);
    assign rx_clr   = rx_clr_q;
    assign tx_clr   = tx_clr_q;
    assign ier_o    = regs_q.ier;
    assign lcr_o    = regs_q.lcr;
    assign mcr_o    = regs_q.mcr;
    assign fcr_o    = regs_q.fcr;
    assign efr_o    = regs_q.efr;
    assign div_lo_o = regs_q.div_lo;
    assign div_hi_o = regs_q.div_hi;
    assign xon1_o   = regs_q.flow[0];
    assign xon2_o   = regs_q.flow[1];
    assign xoff1_o  = regs_q.flow[2];
    assign xoff2_o  = regs_q.flow[3];
    assign tcr_o    = regs_q.tcr;
    assign tlr_o    = regs_q.tlr;
    assign mdr_o    = regs_q.mode;
    assign scr_o    = regs_q.scr;

    // R3: divisor byte moves only through a write at offset 0 with bit 7 set
    a_r3_divlo_guard: assert property (@(posedge clk) disable iff (rst)
        (div_lo_o != $past(div_lo_o)) |->
            ($past(lcr_o[7]) && $past(wr_en) && $past(addr) == 5'd0));

    // R4: enhanced-feature register moves only inside the key bank
    a_r4_efr_guard: assert property (@(posedge clk) disable iff (rst)
        (efr_o != $past(efr_o)) |->
            ($past(lcr_o) == 8'hBF && $past(wr_en) && $past(addr) == 5'd2));

    // R7: receive clear pulse has a qualifying FIFO control write behind it
    a_r7_rxclr_cause: assert property (@(posedge clk) disable iff (rst)
        rx_clr |-> ($past(wr_en) && $past(addr) == 5'd2 &&
                    $past(wr_data[1]) && $past(efr_o[4])));

    // R8: modem-control bit 6 frozen while enhanced bit 4 was low
    a_r8_mcr6_lock: assert property (@(posedge clk) disable iff (rst)
        !$past(efr_o[4]) |-> (mcr_o[6] == $past(mcr_o[6])));

    // R10: push and pop only on offset 0 outside the divisor bank
    a_r10_push_site: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> (wr_en && addr == 5'd0 && !lcr_o[7]));
    a_r10_pop_site: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (rd_en && addr == 5'd0 && !lcr_o[7]));

endmodule

// File: tb/uart_cfg_regfile_tb.sv
`timescale 1ns/1ps
module uart_cfg_regfile_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] rx_data_in = 8'hA5;
    logic [7:0] iir_in = 8'hC1;
    logic [7:0] lsr_in = 8'h61;
    logic [7:0] msr_in = 8'hB0;
    logic [7:0] ssr_in = 8'h02;
    logic       tx_push, rx_pop, rx_clr, tx_clr;
    logic [7:0] ier_o, lcr_o, mcr_o, fcr_o, efr_o, div_lo_o, div_hi_o;
    logic [7:0] xon1_o, xon2_o, xoff1_o, xoff2_o, tcr_o, tlr_o, mdr_o, scr_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_cfg_regfile dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_data_in(rx_data_in),
        .iir_in(iir_in), .lsr_in(lsr_in), .msr_in(msr_in), .ssr_in(ssr_in),
        .tx_push(tx_push), .rx_pop(rx_pop), .rx_clr(rx_clr), .tx_clr(tx_clr),
        .ier_o(ier_o), .lcr_o(lcr_o), .mcr_o(mcr_o), .fcr_o(fcr_o),
        .efr_o(efr_o), .div_lo_o(div_lo_o), .div_hi_o(div_hi_o),
        .xon1_o(xon1_o), .xon2_o(xon2_o), .xoff1_o(xoff1_o), .xoff2_o(xoff2_o),
        .tcr_o(tcr_o), .tlr_o(tlr_o), .mdr_o(mdr_o), .scr_o(scr_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d, output logic pop);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        d = rd_data; pop = rx_pop;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic p;
        rd(5'h01, d, p); chk("R1 ier", d, 8'h00);
        rd(5'h03, d, p); chk("R1 lcr", d, 8'h00);
        rd(5'h08, d, p); chk("R1 mode", d, 8'h07);
        chk("R1 efr", efr_o, 8'h00);
        chk("R1 fcr", fcr_o, 8'h00);
        chk("R1 div", div_lo_o | div_hi_o, 8'h00);
    endtask

    task automatic t_normal_map();
        logic [7:0] d; logic p;
        wr(5'h01, 8'h0F); rd(5'h01, d, p); chk("R2 ier", d, 8'h0F);
        chk("R2 ier_o", ier_o, 8'h0F);
        wr(5'h03, 8'h03); rd(5'h03, d, p); chk("R2 lcr", d, 8'h03);
        wr(5'h07, 8'h5A); rd(5'h07, d, p); chk("R2 spr", d, 8'h5A);
        wr(5'h08, 8'h00); rd(5'h08, d, p); chk("R2 mode", d, 8'h00);
        wr(5'h10, 8'h01); rd(5'h10, d, p); chk("R2 scr", d, 8'h01);
        rd(5'h02, d, p); chk("R2 iir", d, 8'hC1);
        rd(5'h05, d, p); chk("R2 lsr", d, 8'h61);
        rd(5'h06, d, p); chk("R2 msr", d, 8'hB0);
        rd(5'h11, d, p); chk("R2 ssr", d, 8'h02);
    endtask

    task automatic t_data_port();
        logic [7:0] d; logic p;
        @(negedge clk);
        addr = 5'h00; wr_data = 8'h3C; wr_en = 1'b1;
        #1 chk("R10 push", {7'd0, tx_push}, 8'h01);
        @(negedge clk); wr_en = 1'b0;
        #1 chk("R10 push idle", {7'd0, tx_push}, 8'h00);
        rd(5'h00, d, p);
        chk("R10 rx data", d, 8'hA5);
        chk("R10 pop", {7'd0, p}, 8'h01);
    endtask

    task automatic t_divisor_bank();
        logic [7:0] d; logic p;
        wr(5'h03, 8'h83);
        @(negedge clk);
        addr = 5'h00; wr_data = 8'h07; wr_en = 1'b1;
        #1 chk("R3 no push", {7'd0, tx_push}, 8'h00);
        @(negedge clk); wr_en = 1'b0;
        wr(5'h01, 8'h12);
        chk("R3 div_lo", div_lo_o, 8'h07);
        chk("R3 div_hi", div_hi_o, 8'h12);
        rd(5'h00, d, p); chk("R3 read lo", d, 8'h07);
        chk("R3 no pop", {7'd0, p}, 8'h00);
        chk("R3 ier kept", ier_o, 8'h0F);
        wr(5'h03, 8'h03);
    endtask

    task automatic t_fcr_locked();
        wr(5'h02, 8'hC1);
        chk("R6 fcr ignored", fcr_o, 8'h00);
    endtask

    task automatic t_mcr_locked();
        wr(5'h04, 8'h43);
        chk("R8 mcr6 locked", mcr_o, 8'h03);
    endtask

    task automatic t_key_bank();
        logic [7:0] d; logic p;
        wr(5'h03, 8'hBF);
        wr(5'h02, 8'h10);
        wr(5'h04, 8'h11); wr(5'h05, 8'h13); wr(5'h06, 8'h91); wr(5'h07, 8'h93);
        chk("R4 efr", efr_o, 8'h10);
        chk("R4 xon1", xon1_o, 8'h11);
        chk("R4 xon2", xon2_o, 8'h13);
        chk("R4 xoff1", xoff1_o, 8'h91);
        chk("R4 xoff2", xoff2_o, 8'h93);
        rd(5'h06, d, p); chk("R4 read xoff1", d, 8'h91);
        chk("R4 mcr kept", mcr_o, 8'h03);
        wr(5'h03, 8'h03);
    endtask

    task automatic t_fcr_clear();
        wr(5'h02, 8'hF7);
        chk("R7 rx_clr pulse", {7'd0, rx_clr}, 8'h01);
        chk("R7 tx_clr pulse", {7'd0, tx_clr}, 8'h01);
        chk("R7 fcr fields", fcr_o, 8'hF1);
        @(negedge clk);
        chk("R7 rx_clr end", {7'd0, rx_clr}, 8'h00);
        chk("R7 tx_clr end", {7'd0, tx_clr}, 8'h00);
        wr(5'h02, 8'h09);
        chk("R6 fcr loaded", fcr_o, 8'h09);
    endtask

    task automatic t_mcr_open();
        wr(5'h04, 8'h43);
        chk("R8 mcr6 set", mcr_o, 8'h43);
    endtask

    task automatic t_tcr_bank();
        logic [7:0] d; logic p;
        wr(5'h06, 8'h12); wr(5'h07, 8'h34);
        chk("R5 tcr", tcr_o, 8'h12);
        chk("R5 tlr", tlr_o, 8'h34);
        rd(5'h07, d, p); chk("R5 read tlr", d, 8'h34);
        rd(5'h07, d, p); chk("R5 spr kept", d, 8'h34);
        wr(5'h04, 8'h03);
        rd(5'h06, d, p); chk("R5 msr back", d, 8'hB0);
        rd(5'h07, d, p); chk("R5 spr back", d, 8'h5A);
    endtask

    task automatic t_unmapped();
        logic [7:0] d; logic p;
        rd(5'h1F, d, p);
        chk("R9 read zero", d, 8'h00);
        chk("R9 no pop", {7'd0, p}, 8'h00);
        wr(5'h1F, 8'hFF);
        rd(5'h03, d, p); chk("R9 lcr kept", d, 8'h03);
        rd(5'h01, d, p); chk("R9 ier kept", d, 8'h0F);
        rd(5'h07, d, p); chk("R9 spr kept", d, 8'h5A);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d; logic p;
        @(negedge clk);
        addr = 5'h03; wr_data = 8'h83; wr_en = 1'b1; rd_en = 1'b1;
        #1 chk("R11 old lcr", rd_data, 8'h03);
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        rd(5'h00, d, p); chk("R11 new bank", d, 8'h07);
        wr(5'h03, 8'h03);
        @(negedge clk);
        addr = 5'h00; wr_data = 8'h55; wr_en = 1'b1; rd_en = 1'b1;
        #1;
        chk("R11 rd data", rd_data, 8'hA5);
        chk("R11 push+pop", {6'd0, tx_push, rx_pop}, 8'h03);
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_normal_map();
        t_data_port();
        t_divisor_bank();
        t_fcr_locked();
        t_mcr_locked();
        t_key_bank();
        t_fcr_clear();
        t_mcr_open();
        t_tcr_bank();
        t_unmapped();
        t_same_cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule